// File: doc/BRIEF.md
# Digital DLL Compensation and Lock Controller

This block is the digital control loop of a delay-locked loop whose delay line is a chain of four programmable buffers. Each buffer carries binary-weighted trim elements (weights 1, 2, 4, 8 and 16) that a 5-bit compensation code switches in. The line is locked to the high phase of a 50% duty-cycle reference clock, which is half a period, so only four buffers are needed. A single flip-flop phase detector gives one early/late bit per reference cycle. The block turns that stream of decisions into a stable compensation code and a lock flag.

Each decision first enters a signed accumulator, which acts as a digital low-pass filter. Only when the accumulator reaches a set threshold does the saturating compensation counter move by one. The code is then sent unchanged to remote slave delay lines built from copies of the same buffers. The master passes on the code, not a delayed clock.

A lock detector splits the decision stream into back-to-back 16-sample windows. Its two-state machine works as follows:
- In state ACQUIRE, a window that ends perfectly balanced (transition ACQ_TO_TRACK) moves it to TRACK.
- In state TRACK, a window whose imbalance exceeds a small tolerance (transition TRACK_TO_ACQ) sends it back to ACQUIRE.
- Any other window end leaves the state where it is (transitions ACQ_STAY and TRACK_STAY).

A freeze input holds the code, the filter and the lock state while a test runs.

Top module: `dll_comp_ctrl`

## Requirements
- R1: While reset is low and after it is released, the code is RESET_CODE (default 16, binary 10000), locked is 0, the filter accumulator is zero and the window position is zero.
- R2: Each unfrozen sample adds +1 (pd_up=1, line too short) or -1 (pd_up=0) to the accumulator. Reaching +FILT_TH (default 4) issues one up step and reaching -FILT_TH issues one down step, and either one clears the accumulator. No step is issued while the magnitude stays below FILT_TH.
- R3: A step changes the code by exactly one. The change is visible after the clock edge that follows the edge sampling the decision that crossed the threshold. After a change, the code holds for at least one further cycle.
- R4: The code saturates at 31 and at 0. An up step at 31 and a down step at 0 leave it unchanged, and it never wraps.
- R5: Unfrozen samples are grouped into back-to-back windows of WIN_LEN (16) samples, counted from reset release. In ACQUIRE, a window with equal up and down counts moves to TRACK, and locked is 1 after the edge that samples the window's last decision.
- R6: In TRACK, a window with |ups - downs| greater than LOCK_TOL (default 2) returns to ACQUIRE and clears locked. A window with imbalance of LOCK_TOL or less keeps the lock.
- R7: While freeze is 1 at a clock edge, the decision is ignored. The code, lock state, accumulator and window position all hold. A step issued at the edge just before is discarded.
- R8: In a closed loop with a four-buffer line compared against half the reference period, the code settles and then stays within the two adjacent codes around the equilibrium.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_up | input | 1 | Phase detector decision, 1 = line too short (raise code) |
| freeze | input | 1 | Holds code, filter and lock state |
| comp_code | output | CODE_W | Compensation code broadcast to master and slave lines |
| locked | output | 1 | Lock flag (1 in TRACK state) |

## Verification
The bench builds the block with its defaults: a 5-bit code reset to 16, a filter threshold of 4, 16-sample windows and a lock tolerance of 2. With a threshold of 4, a few dozen samples are enough to push the code to both saturation rails. The 16-sample window keeps exact lock boundaries easy to reach, including an imbalance of exactly 2 (lock kept) and 16 (lock lost). A behavioural four-buffer line in the bench closes the loop so that the code can be seen to settle around its equilibrium.

// File: rtl/dll_pkg.sv
package dll_pkg;
    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DN   = 2'b10
    } step_e;

    typedef enum logic {
        LK_ACQUIRE = 1'b0,
        LK_TRACK   = 1'b1
    } lock_state_e;
endpackage

// File: rtl/dll_loop_filter.sv
module dll_loop_filter
    import dll_pkg::*;
#(
    parameter int FILT_TH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hold,
    input  logic  pd_up,
    output step_e step_o
);
    localparam int ACC_W = $clog2(FILT_TH) + 2;
    localparam logic signed [ACC_W-1:0] TH_POS = ACC_W'(FILT_TH);
    localparam logic signed [ACC_W-1:0] TH_NEG = -TH_POS;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_inc;

    always_comb begin
        acc_inc = pd_up ? (acc_q + ACC_W'(1)) : (acc_q - ACC_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            step_o <= STEP_NONE;
        end else if (hold) begin
            step_o <= STEP_NONE;
        end else if (acc_inc == TH_POS) begin
            acc_q  <= '0;
            step_o <= STEP_UP;
        end else if (acc_inc == TH_NEG) begin
            acc_q  <= '0;
            step_o <= STEP_DN;
        end else begin
            acc_q  <= acc_inc;
            step_o <= STEP_NONE;
        end
    end
endmodule

// File: rtl/dll_comp_counter.sv
module dll_comp_counter
    import dll_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int RESET_CODE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  step_e             step_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(RESET_CODE);

    logic [CODE_W-1:0] code_nxt;

    always_comb begin
        code_nxt = code_o;
        if (!hold) begin
            unique case (step_i)
                STEP_UP:   if (code_o != CODE_MAX) code_nxt = code_o + CODE_W'(1);
                STEP_DN:   if (code_o != '0)       code_nxt = code_o - CODE_W'(1);
                default:   code_nxt = code_o;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) code_o <= CODE_RST;
        else        code_o <= code_nxt;
    end
endmodule

// File: rtl/dll_lock_detect.sv
module dll_lock_detect
    import dll_pkg::*;
#(
    parameter int WIN_LEN  = 16,
    parameter int LOCK_TOL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic pd_up,
    output logic locked_o
);
    localparam int WIN_W = $clog2(WIN_LEN);
    localparam int BAL_W = $clog2(WIN_LEN + 1) + 1;
    localparam logic [WIN_W-1:0]        WIN_LAST = WIN_W'(WIN_LEN - 1);
    localparam logic signed [BAL_W-1:0] TOL_POS  = BAL_W'(LOCK_TOL);
    localparam logic signed [BAL_W-1:0] TOL_NEG  = -TOL_POS;

    lock_state_e             state_q, state_d;
    logic [WIN_W-1:0]        win_q;
    logic signed [BAL_W-1:0] bal_q, bal_nxt;
    logic                    win_end, balanced, over_tol;

    always_comb begin
        bal_nxt  = pd_up ? (bal_q + BAL_W'(1)) : (bal_q - BAL_W'(1));
        win_end  = !hold && (win_q == WIN_LAST);
        balanced = (bal_nxt == '0);
        over_tol = (bal_nxt > TOL_POS) || (bal_nxt < TOL_NEG);
    end

    // window position and running balance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
            bal_q <= '0;
        end else if (!hold) begin
            if (win_q == WIN_LAST) begin
                win_q <= '0;
                bal_q <= '0;
            end else begin
                win_q <= win_q + WIN_W'(1);
                bal_q <= bal_nxt;
            end
        end
    end

    // next state: ACQ_TO_TRACK, ACQ_STAY, TRACK_TO_ACQ, TRACK_STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_ACQUIRE: if (win_end && balanced) state_d = LK_TRACK;
            LK_TRACK:   if (win_end && over_tol) state_d = LK_ACQUIRE;
            default:    state_d = LK_ACQUIRE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_ACQUIRE;
        else        state_q <= state_d;
    end

    always_comb begin
        locked_o = (state_q == LK_TRACK);
    end
endmodule

// File: rtl/dll_comp_ctrl.sv
module dll_comp_ctrl
    import dll_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int RESET_CODE = 16,
    parameter int FILT_TH    = 4,
    parameter int WIN_LEN    = 16,
    parameter int LOCK_TOL   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_up,
    input  logic              freeze,
    output logic [CODE_W-1:0] comp_code,
    output logic              locked
);
    step_e step_w;

    dll_loop_filter #(.FILT_TH(FILT_TH)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (freeze),
        .pd_up  (pd_up),
        .step_o (step_w)
    );

    dll_comp_counter #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (freeze),
        .step_i (step_w),
        .code_o (comp_code)
    );

    dll_lock_detect #(.WIN_LEN(WIN_LEN), .LOCK_TOL(LOCK_TOL)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (freeze),
        .pd_up    (pd_up),
        .locked_o (locked)
    );
endmodule

// File: rtl/dll_comp_ctrl_chk.sv
module dll_comp_ctrl_chk #(
    parameter int CODE_W     = 5,
    parameter int RESET_CODE = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              freeze,
    input logic [CODE_W-1:0] comp_code,
    input logic              locked
);
    localparam logic [CODE_W-1:0] CMAX = {CODE_W{1'b1}};

    a_r1_reset_code: assert property (@(posedge clk)
        !rst_n |=> (comp_code == CODE_W'(RESET_CODE)) && !locked);

    a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(comp_code) |->
            (comp_code == $past(comp_code) + CODE_W'(1)) ||
            (comp_code == $past(comp_code) - CODE_W'(1)));

    a_r3_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && !$stable(comp_code)) |=> $stable(comp_code));

    a_r4_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_code == CMAX) |=> (comp_code != '0));

    a_r4_no_wrap_bot: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_code == '0) |=> (comp_code != CMAX));

    a_r7_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(comp_code) && $stable(locked));
endmodule

bind dll_comp_ctrl dll_comp_ctrl_chk #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze    (freeze),
    .comp_code (comp_code),
    .locked    (locked)
);

// File: tb/dll_comp_ctrl_tb.sv
module dll_comp_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W   = 5;
    localparam int RST_CODE = 16;
    localparam int TH       = 4;
    localparam int WIN      = 16;
    localparam int TOL      = 2;
    // behavioural line: four buffers, each BUF_BASE + BUF_UNIT*code ps
    localparam int BUF_BASE = 100;
    localparam int BUF_UNIT = 3;
    localparam int HALF_PS  = 625;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_up = 1'b0;
    logic freeze = 1'b0;
    logic [CODE_W-1:0] comp_code;
    logic locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_acc = 0, m_step = 0, m_code = RST_CODE, m_win = 0, m_bal = 0;
    bit m_lock = 1'b0;
    logic [CODE_W:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dll_comp_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pd_up(pd_up), .freeze(freeze),
        .comp_code(comp_code), .locked(locked)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_step(input bit pd, input bit frz);
        int nb;
        if (!frz) begin
            if (m_step == 1 && m_code < 31) m_code++;
            if (m_step == -1 && m_code > 0) m_code--;
            m_acc += pd ? 1 : -1;
            m_step = 0;
            if (m_acc == TH) begin m_step = 1; m_acc = 0; end
            else if (m_acc == -TH) begin m_step = -1; m_acc = 0; end
            nb = m_bal + (pd ? 1 : -1);
            if (m_win == WIN - 1) begin
                if (!m_lock && nb == 0) m_lock = 1'b1;
                else if (m_lock && (nb > TOL || nb < -TOL)) m_lock = 1'b0;
                m_win = 0; m_bal = 0;
            end else begin
                m_win++; m_bal = nb;
            end
        end else begin
            m_step = 0;
        end
    endtask

    // driver: applies one sample, pushes expected outputs after the next edge
    task automatic drive(input bit pd, input bit frz);
        pd_up = pd; freeze = frz;
        model_step(pd, frz);
        exp_q.push_back({m_lock, CODE_W'(m_code)});
        @(negedge clk);
    endtask

    // monitor: compares outputs just after each edge
    initial begin
        forever begin
            @(posedge clk); #2;
            if (exp_q.size() > 0) begin
                logic [CODE_W:0] e;
                e = exp_q.pop_front();
                check("R3 code track", comp_code, e[CODE_W-1:0]);
                check("R5 lock track", locked, e[CODE_W]);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset code", comp_code, RST_CODE);
        check("R1 reset lock", locked, 0);
        rst_n = 1'b1;
        // window 1: alternating, balanced
        for (int i = 0; i < 8; i++) begin drive(1, 0); drive(0, 0); end
        check("R5 lock after balanced window", locked, 1);
        check("R2 no step below threshold", comp_code, 16);
        // window 2: imbalance +2, within tolerance
        for (int i = 0; i < 7; i++) begin drive(1, 0); drive(0, 0); end
        drive(1, 0); drive(1, 0);
        check("R6 lock kept at tolerance", locked, 1);
        check("R2 accumulator 2 no step", comp_code, 16);
        // window 3: all up
        for (int i = 0; i < 16; i++) drive(1, 0);
        check("R6 lock lost", locked, 0);
        check("R3 four steps", comp_code, 20);
        // step pending then freeze
        drive(1, 0); drive(1, 0);
        for (int i = 0; i < 20; i++) drive(1, 1);
        check("R7 pending step dropped", comp_code, 20);
        check("R7 lock held", locked, 0);
        // saturation
        for (int i = 0; i < 80; i++) drive(1, 0);
        check("R4 top saturation", comp_code, 31);
        for (int i = 0; i < 160; i++) drive(0, 0);
        check("R4 bottom saturation", comp_code, 0);
        // closed loop with behavioural four-buffer line
        for (int i = 0; i < 300; i++) begin
            bit up;
            up = (4 * (BUF_BASE + BUF_UNIT * int'(comp_code))) < HALF_PS;
            drive(up, 0);
            if (i >= 200) begin
                checks++;
                if (comp_code < 18 || comp_code > 19) begin
                    errors++;
                    $display("FAIL R8 settled code actual=%0d expected=18..19", comp_code);
                end
            end
        end
        @(negedge clk);
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule